// File: doc/BRIEF.md
# Cascadable Debounced Pulse Counter Pair

This block holds two edge counters that tally pulses arriving on external pins. Each channel picks one of its two pins and counts either the rising or the falling transitions of that pin. A channel can filter its pin through a debouncer. The debouncer samples the pin on a slow strobe, nominally 32 kHz, and ignores short glitches and chatter. Without the debouncer, a channel follows the synchronised pin directly and keeps up with pulse rates far below the system clock, such as 100 kHz.

Each channel has a reference value. When an increment takes the count to that value, the channel raises a sticky match flag, which can serve as an interrupt or wake request. Counting carries on after the match. The count never saturates; it wraps to zero. When the cascade control is set, the two channels form one 32-bit counter. Channel 0 supplies the low half and the input pulses. Channel 1 supplies the high half and advances on each wrap of the low half. The match is then judged on the full 32-bit value.

Top module: `pulse_counter_pair`

## Requirements
- R1: After reset both counts read 0 and both match flags read 0.
- R2: When `edge_fall[i]` is 0, channel i adds one per rising edge of its selected pin. When it is 1, channel i adds one per falling edge. A full high-then-low pulse always adds exactly one.
- R3: When `pin_sel[i]` is 0, channel i uses `pin_in[2*i]`. When it is 1, channel i uses `pin_in[2*i+1]`. The other pin of that channel has no effect on its count.
- R4: A count at 0xFFFF that receives an increment becomes 0. It never saturates.
- R5: When an increment makes a channel's count equal to its reference, that channel's match flag is set. Later edges keep incrementing the count.
- R6: A match flag stays at 1 until `flag_clr[i]` is asserted. If a new match and `flag_clr[i]` occur in the same cycle, the flag stays at 1.
- R7: Asserting `cnt_clr[i]` for one cycle sets count i to 0. An edge that lands in that same cycle is discarded.
- R8: While `cascade_en` is 1, count 1 advances exactly when count 0 wraps from 0xFFFF to 0. Channel 1's own pins are ignored.
- R9: While `cascade_en` is 1, the 32-bit value {count 1, count 0} is compared with {reference 1, reference 0}. A match sets only flag 0; flag 1 is never set.
- R10: With `deb_en[i]` set, a new pin level is accepted only after two consecutive `sample_tick` strobes have seen it. A pulse that spans fewer strobes is not counted.
- R11: With debounce off, a pin change made between clock edges shows up in the count after the third rising clock edge that follows it. The count is unchanged after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle strobe at the slow debounce sample rate |
| pin_in | input | 4 | External pulse pins, two per channel (bits 1:0 channel 0, bits 3:2 channel 1) |
| pin_sel | input | 2 | Per-channel pin choice (bit i for channel i) |
| edge_fall | input | 2 | Per-channel edge polarity: 0 rising, 1 falling |
| deb_en | input | 2 | Per-channel debounce enable |
| ref_val | input | 32 | References: bits 15:0 channel 0, bits 31:16 channel 1 |
| cascade_en | input | 1 | Join both channels into one 32-bit counter |
| cnt_clr | input | 2 | Per-channel count clear |
| flag_clr | input | 2 | Per-channel match flag clear |
| count_out | output | 32 | Counts: bits 15:0 channel 0, bits 31:16 channel 1 |
| match_flag | output | 2 | Sticky per-channel match flags |

## Verification
Two kinds of event can land on the same clock edge. The first is a software clear meeting a hardware update: a flag clear arriving in the cycle an increment reaches the reference, or a count clear arriving in the cycle a synchronised edge would increment. The bench starts a pin edge and counts forward to the exact edge where the increment lands, then drives the clear for that one cycle. It expects the flag to survive its clear, and it expects the count to read 0 with the edge lost. The second is the cascade carry: the low half wrapping in the same cycle the combined value reaches the 32-bit reference. It is judged by checking both halves and both flags right after the 65536th pulse.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
   localparam int NUM_CH = 2;

   typedef enum logic {
      POL_RISE = 1'b0,
      POL_FALL = 1'b1
   } edge_pol_e;
endpackage

// File: rtl/pcnt_front.sv
module pcnt_front #(
   parameter int PIN_PER_CH  = 2,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W = (PIN_PER_CH > 1) ? $clog2(PIN_PER_CH) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sample_tick,
   input  logic [PIN_PER_CH-1:0] pins,
   input  logic [SEL_W-1:0]      sel,
   input  logic                  fall,
   input  logic                  deb_en,
   output logic                  edge_pulse
);
   import pcnt_pkg::*;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pcnt_front: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic                   raw_pin;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   samp_q;
   logic                   deb_q;
   logic                   level;
   logic                   level_q;

   assign raw_pin = pins[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_pin};
   end

   // Debounce: accept a level only when two successive strobes agree.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_q <= 1'b0;
         deb_q  <= 1'b0;
      end else if (sample_tick) begin
         samp_q <= sync_q[SYNC_STAGES-1];
         if (samp_q == sync_q[SYNC_STAGES-1]) deb_q <= samp_q;
      end
   end

   assign level = deb_en ? deb_q : sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   always_comb begin
      if (edge_pol_e'(fall) == POL_FALL) edge_pulse = level_q & ~level;
      else                               edge_pulse = level & ~level_q;
   end

   // R10: the filtered level moves only on a sample strobe
   assert_deb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_tick |=> $stable(deb_q));
endmodule

// File: rtl/pcnt_core.sv
module pcnt_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   input  logic [CNT_W-1:0] ref_val,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             wrap,
   output logic             hit
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_comb begin
      if (clr)      cnt_nxt = '0;
      else if (inc) cnt_nxt = cnt + 1'b1;
      else          cnt_nxt = cnt;
   end

   assign wrap = inc & ~clr & (cnt == CNT_MAX);
   assign hit  = inc & ~clr & (cnt_nxt == ref_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

   assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && cnt == CNT_MAX) |=> (cnt == '0));
   assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/pulse_counter_pair.sv
module pulse_counter_pair #(
   parameter int CNT_W       = 16,
   parameter int PIN_PER_CH  = 2,
   parameter int SYNC_STAGES = 2,
   localparam int NCH   = pcnt_pkg::NUM_CH,
   localparam int SEL_W = (PIN_PER_CH > 1) ? $clog2(PIN_PER_CH) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sample_tick,
   input  logic [NCH*PIN_PER_CH-1:0] pin_in,
   input  logic [NCH*SEL_W-1:0]      pin_sel,
   input  logic [NCH-1:0]            edge_fall,
   input  logic [NCH-1:0]            deb_en,
   input  logic [NCH*CNT_W-1:0]      ref_val,
   input  logic                      cascade_en,
   input  logic [NCH-1:0]            cnt_clr,
   input  logic [NCH-1:0]            flag_clr,
   output logic [NCH*CNT_W-1:0]      count_out,
   output logic [NCH-1:0]            match_flag
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("pulse_counter_pair: CNT_W must be at least 2");
      end
      if (PIN_PER_CH < 1) begin : g_bad_pins
         $error("pulse_counter_pair: PIN_PER_CH must be at least 1");
      end
   endgenerate

   logic [NCH-1:0]       edge_v;
   logic [NCH-1:0]       inc_v;
   logic [NCH-1:0]       wrap_v;
   logic [NCH-1:0]       hit_v;
   logic [NCH-1:0]       set_v;
   logic [NCH*CNT_W-1:0] nxt_v;
   logic                 wide_hit;

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         pcnt_front #(
            .PIN_PER_CH (PIN_PER_CH),
            .SYNC_STAGES(SYNC_STAGES)
         ) u_front (
            .clk        (clk),
            .rst_n      (rst_n),
            .sample_tick(sample_tick),
            .pins       (pin_in[g*PIN_PER_CH +: PIN_PER_CH]),
            .sel        (pin_sel[g*SEL_W +: SEL_W]),
            .fall       (edge_fall[g]),
            .deb_en     (deb_en[g]),
            .edge_pulse (edge_v[g])
         );

         pcnt_core #(.CNT_W(CNT_W)) u_core (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (inc_v[g]),
            .clr    (cnt_clr[g]),
            .ref_val(ref_val[g*CNT_W +: CNT_W]),
            .cnt    (count_out[g*CNT_W +: CNT_W]),
            .cnt_nxt(nxt_v[g*CNT_W +: CNT_W]),
            .wrap   (wrap_v[g]),
            .hit    (hit_v[g])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           match_flag[g] <= 1'b0;
            else if (set_v[g])    match_flag[g] <= 1'b1;
            else if (flag_clr[g]) match_flag[g] <= 1'b0;
         end

         assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (match_flag[g] && !flag_clr[g]) |=> match_flag[g]);
      end
   endgenerate

   // Cascade: high half is fed by the low half's carry-out.
   assign inc_v[0] = edge_v[0];
   assign inc_v[1] = cascade_en ? wrap_v[0] : edge_v[1];

   assign wide_hit = inc_v[0] & ~cnt_clr[0] & (nxt_v == ref_val);

   assign set_v[0] = cascade_en ? wide_hit : hit_v[0];
   assign set_v[1] = cascade_en ? 1'b0     : hit_v[1];

   assert_casc_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cascade_en && !match_flag[1]) |=> !match_flag[1]);
   assert_casc_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cascade_en && !cnt_clr[1] && !cnt_clr[0] && count_out[CNT_W-1:0] != '0)
      |=> $stable(count_out[2*CNT_W-1:CNT_W]) || (count_out[CNT_W-1:0] == '0));
endmodule

// File: tb/tb_pulse_counter_pair.sv
module tb_pulse_counter_pair;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic       ch;
      logic       sel;
      logic       fall;
      logic [3:0] npulse;
      logic [3:0] noise;
      logic [15:0] expc;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{1'b0, 1'b0, 1'b0, 4'd3, 4'd2, 16'd3},
      '{1'b0, 1'b1, 1'b1, 4'd5, 4'd1, 16'd5},
      '{1'b1, 1'b0, 1'b0, 4'd2, 4'd4, 16'd2},
      '{1'b1, 1'b1, 1'b1, 4'd4, 4'd0, 16'd4},
      '{1'b0, 1'b1, 1'b0, 4'd1, 4'd3, 16'd1},
      '{1'b1, 1'b0, 1'b1, 4'd6, 4'd2, 16'd6}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_tick = 1'b0;
   logic [3:0]  pin_in = '0;
   logic [1:0]  pin_sel = '0;
   logic [1:0]  edge_fall = '0;
   logic [1:0]  deb_en = '0;
   logic [31:0] ref_val = '1;
   logic        cascade_en = 1'b0;
   logic [1:0]  cnt_clr = '0;
   logic [1:0]  flag_clr = '0;
   logic [31:0] count_out;
   logic [1:0]  match_flag;

   int checks = 0;
   int errors = 0;

   pulse_counter_pair dut (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .pin_in(pin_in),
      .pin_sel(pin_sel), .edge_fall(edge_fall), .deb_en(deb_en),
      .ref_val(ref_val), .cascade_en(cascade_en), .cnt_clr(cnt_clr),
      .flag_clr(flag_clr), .count_out(count_out), .match_flag(match_flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      forever begin
         repeat (7) @(negedge clk);
         sample_tick = 1'b1;
         @(negedge clk);
         sample_tick = 1'b0;
      end
   end

   initial begin
      repeat (195000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pulse(input int pin, input int hold);
      @(negedge clk); pin_in[pin] = 1'b1;
      repeat (hold) @(negedge clk);
      pin_in[pin] = 1'b0;
      repeat (hold) @(negedge clk);
   endtask

   task automatic clear_all();
      @(negedge clk); cnt_clr = 2'b11; flag_clr = 2'b11;
      @(negedge clk); cnt_clr = 2'b00; flag_clr = 2'b00;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 counts", count_out, 32'h0);
      chk("R1 flags", {30'h0, match_flag}, 32'h0);

      // Table walk: polarity, pin choice, noise on the unused pin (R2, R3)
      foreach (VECS[k]) begin
         clear_all();
         pin_sel[VECS[k].ch]   = VECS[k].sel;
         edge_fall[VECS[k].ch] = VECS[k].fall;
         for (int p = 0; p < VECS[k].npulse; p++)
            pulse(2*VECS[k].ch + VECS[k].sel, 4);
         for (int p = 0; p < VECS[k].noise; p++)
            pulse(2*VECS[k].ch + (VECS[k].sel ? 0 : 1), 4);
         if (VECS[k].ch)
            chk("R2 R3 ch1 count", {16'h0, count_out[31:16]}, {16'h0, VECS[k].expc});
         else
            chk("R2 R3 ch0 count", {16'h0, count_out[15:0]}, {16'h0, VECS[k].expc});
      end

      // R11 latency
      pin_sel = 2'b00; edge_fall = 2'b00;
      clear_all();
      @(negedge clk); pin_in[0] = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R11 before third edge", {16'h0, count_out[15:0]}, 32'h0);
      @(negedge clk);
      chk("R11 after third edge", {16'h0, count_out[15:0]}, 32'h1);
      pin_in[0] = 1'b0;
      repeat (4) @(negedge clk);

      // R7 clear coinciding with an increment
      @(negedge clk); pin_in[0] = 1'b1;
      @(negedge clk); @(negedge clk);
      cnt_clr[0] = 1'b1;
      @(negedge clk); cnt_clr[0] = 1'b0;
      chk("R7 clear beats edge", {16'h0, count_out[15:0]}, 32'h0);
      pin_in[0] = 1'b0;
      repeat (4) @(negedge clk);

      // R5 / R6 on channel 1
      ref_val = {16'd3, 16'hFFFF};
      clear_all();
      pulse(2, 4); pulse(2, 4);
      chk("R5 no match yet", {30'h0, match_flag}, 32'h0);
      pulse(2, 4);
      chk("R5 match set", {30'h0, match_flag}, 32'h2);
      pulse(2, 4); pulse(2, 4);
      chk("R5 keeps counting", {16'h0, count_out[31:16]}, 32'd5);
      chk("R6 flag sticky", {30'h0, match_flag}, 32'h2);
      @(negedge clk); flag_clr[1] = 1'b1;
      @(negedge clk); flag_clr[1] = 1'b0;
      chk("R6 flag cleared", {30'h0, match_flag}, 32'h0);

      // R6 set and clear in the same cycle
      ref_val = {16'd6, 16'hFFFF};
      @(negedge clk); pin_in[2] = 1'b1;
      @(negedge clk); @(negedge clk);
      flag_clr[1] = 1'b1;
      @(negedge clk); flag_clr[1] = 1'b0;
      chk("R6 set wins over clear", {30'h0, match_flag}, 32'h2);
      chk("R5 count at ref", {16'h0, count_out[31:16]}, 32'd6);
      pin_in[2] = 1'b0;
      repeat (4) @(negedge clk);

      // R4 / R8 / R9 cascade wrap
      cascade_en = 1'b1;
      ref_val = {16'h0001, 16'h0000};
      clear_all();
      for (int p = 0; p < 65535; p++) begin
         @(negedge clk); pin_in[0] = 1'b1;
         @(negedge clk); pin_in[0] = 1'b0;
      end
      repeat (4) @(negedge clk);
      chk("R4 low half at max", count_out, 32'h0000FFFF);
      chk("R9 no early match", {30'h0, match_flag}, 32'h0);
      pulse(0, 4);
      chk("R4 R8 wrap carries", count_out, 32'h00010000);
      chk("R9 wide match on flag0 only", {30'h0, match_flag}, 32'h1);
      pulse(2, 4); pulse(3, 4);
      chk("R8 channel1 pins ignored", count_out, 32'h00010000);
      cascade_en = 1'b0;

      // R10 debounce on channel 0
      ref_val = '1;
      repeat (40) @(negedge clk);
      clear_all();
      deb_en[0] = 1'b1;
      pulse(0, 3);
      repeat (30) @(negedge clk);
      chk("R10 glitch rejected", {16'h0, count_out[15:0]}, 32'h0);
      pulse(0, 40);
      chk("R10 stable pulse counted", {16'h0, count_out[15:0]}, 32'h1);
      deb_en[0] = 1'b0;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule